// File: doc/BRIEF.md
# Grouped pin-change interrupt unit

This block watches twelve general-purpose input pins and raises an interrupt when any of them toggles. The pins form two groups of unequal size. The low group holds pins 0 to 7 and the high group holds pins 8 to 11. Each group has its own enable mask and its own pending flag. A rising or a falling transition on any enabled pin sets the flag of that pin's group. The flag stays set until software clears it with a one-cycle strobe. A toggle is still seen when the pin is being driven by the chip itself, so firmware can raise an interrupt on purpose.

Each pin passes through a level latch that is open while the clock is low. A register then samples the latch on the rising edge. A pin has changed when the latch and the register disagree. That difference, gated by the mask bit, is the set request into the group flag.

Each group also has a wake output. It is a purely combinational comparison of the live pins against their last sampled values, so it still signals a change while the clock is stopped. A power controller can use it to restart the clock.

Top module: `pin_change_irq`

## Requirements
- R1: After reset both flags (`irq_lo`, `irq_hi`) are 0, both masks are 0 and both wake outputs are 0.
- R2: A rising or a falling toggle on an enabled pin of bits 0..7 of `pins` sets `irq_lo` and leaves `irq_hi` at 0.
- R3: A rising or a falling toggle on an enabled pin of bits 8..11 of `pins` sets `irq_hi` and leaves `irq_lo` at 0.
- R4: A toggle on a pin whose mask bit is 0 sets no flag and does not assert the wake output. Re-enabling that pin afterwards does not raise a stale change.
- R5: If a pin changes while the clock is high, the flag is still 0 before the next rising edge and is 1 just after it. Capture happens at the falling edge that opens the latch.
- R6: A set flag holds over idle cycles. It reads 0 after the rising edge at which its clear input (`clr_lo` / `clr_hi`) is 1 with no new change.
- R7: When a change and a clear of the same group meet at one rising edge, the flag is 1 afterwards (set wins).
- R8: `wake_lo` / `wake_hi` is 1 whenever an enabled pin of the group differs from its last sampled value, with no clock edge needed. This includes while the clock is stopped. When the clock restarts, the first rising edge sets the flag and drops the wake output.
- R9: A mask write strobe loads its data at the next rising edge. Mask bit k of `mask_lo_d` enables pin k, and mask bit k of `mask_hi_d` enables pin 8+k. Each group's mask is written independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also opens the pin latches while low |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 12 | Pin levels, bit k is pin k |
| mask_lo_we | input | 1 | Write strobe for the low-group mask |
| mask_lo_d | input | 8 | New low-group mask, bit k enables pin k |
| mask_hi_we | input | 1 | Write strobe for the high-group mask |
| mask_hi_d | input | 4 | New high-group mask, bit k enables pin 8+k |
| clr_lo | input | 1 | Clear strobe for the low-group flag |
| clr_hi | input | 1 | Clear strobe for the high-group flag |
| irq_lo | output | 1 | Low-group pending flag |
| irq_hi | output | 1 | High-group pending flag |
| wake_lo | output | 1 | Combinational low-group change request |
| wake_hi | output | 1 | Combinational high-group change request |

## Verification
A wrong sampled pin value shows up at once as a wake output that is stuck high, or one that never rises, in the same half cycle as the toggle. It then shows up as a missing or spurious flag one rising edge later. A pin mapped to the wrong group or mask bit is exposed by sweeping every pin in both directions with full masks, and again with only that pin disabled. Latency errors are caught by sampling each flag just before and just after the one rising edge where it must change. A stopped-clock phase confirms that the wake path works with no edge at all.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int LO_W = 8,
  parameter int HI_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LO_W+HI_W-1:0] pins,
  input  logic                 mask_lo_we,
  input  logic [LO_W-1:0]      mask_lo_d,
  input  logic                 mask_hi_we,
  input  logic [HI_W-1:0]      mask_hi_d,
  input  logic                 clr_lo,
  input  logic                 clr_hi,
  output logic                 irq_lo,
  output logic                 irq_hi,
  output logic                 wake_lo,
  output logic                 wake_hi
);
  localparam int N = LO_W + HI_W;

  logic [LO_W-1:0] mask_lo;
  logic [HI_W-1:0] mask_hi;
  logic [N-1:0]    pin_lat, pin_smp, en, set_vec, chg_vec;
  logic            set_lo, set_hi;

  always_latch
    if (!clk) pin_lat = pins;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_smp <= '0;
    else        pin_smp <= pin_lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_lo <= '0;
      mask_hi <= '0;
    end else begin
      if (mask_lo_we) mask_lo <= mask_lo_d;
      if (mask_hi_we) mask_hi <= mask_hi_d;
    end

  assign en      = {mask_hi, mask_lo};
  assign set_vec = (pin_lat ^ pin_smp) & en;
  assign chg_vec = (pins ^ pin_smp) & en;
  assign set_lo  = |set_vec[LO_W-1:0];
  assign set_hi  = |set_vec[N-1:LO_W];
  assign wake_lo = |chg_vec[LO_W-1:0];
  assign wake_hi = |chg_vec[N-1:LO_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      if (set_lo)      irq_lo <= 1'b1;
      else if (clr_lo) irq_lo <= 1'b0;
      if (set_hi)      irq_hi <= 1'b1;
      else if (clr_hi) irq_hi <= 1'b0;
    end

  // R7
  set_wins_lo_chk: assert property (@(posedge clk) disable iff (!rst_n) set_lo |=> irq_lo);
  // R7
  set_wins_hi_chk: assert property (@(posedge clk) disable iff (!rst_n) set_hi |=> irq_hi);
  // R6
  clear_lo_chk: assert property (@(posedge clk) disable iff (!rst_n) (clr_lo && !set_lo) |=> !irq_lo);
  // R6
  hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n) (!clr_hi && !set_hi) |=> $stable(irq_hi));
  // R4
  masked_lo_chk: assert property (@(posedge clk) disable iff (!rst_n) (mask_lo == '0) |-> (!wake_lo && !set_lo));
  // R4
  masked_hi_chk: assert property (@(posedge clk) disable iff (!rst_n) (mask_hi == '0) |-> (!wake_hi && !set_hi));
endmodule

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  localparam int LO_W = 8;
  localparam int HI_W = 4;
  localparam int N = LO_W + HI_W;

  logic clk = 1'b0, clk_en = 1'b1, rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic mask_lo_we = 0, mask_hi_we = 0, clr_lo = 0, clr_hi = 0;
  logic [LO_W-1:0] mask_lo_d = '0;
  logic [HI_W-1:0] mask_hi_d = '0;
  logic irq_lo, irq_hi, wake_lo, wake_hi;
  int checks = 0, failures = 0;
  bit done = 0;

  pin_change_irq #(.LO_W(LO_W), .HI_W(HI_W)) u_pin_change_irq (
    .clk(clk), .rst_n(rst_n), .pins(pins),
    .mask_lo_we(mask_lo_we), .mask_lo_d(mask_lo_d),
    .mask_hi_we(mask_hi_we), .mask_hi_d(mask_hi_d),
    .clr_lo(clr_lo), .clr_hi(clr_hi),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .wake_lo(wake_lo), .wake_hi(wake_hi));

  always begin
    #10;
    if (clk_en) clk = ~clk;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic write_masks(input logic [LO_W-1:0] m_lo, input logic [HI_W-1:0] m_hi);
    mask_lo_d = m_lo; mask_hi_d = m_hi;
    mask_lo_we = 1; mask_hi_we = 1;
    tick();
    mask_lo_we = 0; mask_hi_we = 0;
  endtask

  task automatic clear_both();
    clr_lo = 1; clr_hi = 1;
    tick();
    clr_lo = 0; clr_hi = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1;
    tick();
    // R1
    chk("R1 irq_lo", irq_lo, 0);
    chk("R1 irq_hi", irq_hi, 0);
    chk("R1 wake_lo", wake_lo, 0);
    chk("R1 wake_hi", wake_hi, 0);
    pins[0] = 1; pins[9] = 1;
    #10;
    chk("R1 masks off wake_lo", wake_lo, 0);
    chk("R1 masks off wake_hi", wake_hi, 0);
    tick();
    chk("R1 masks off irq_lo", irq_lo, 0);
    chk("R1 masks off irq_hi", irq_hi, 0);
    pins = '0;
    tick(); tick();

    // R9: independent group writes
    mask_lo_d = '1; mask_lo_we = 1; tick(); mask_lo_we = 0;
    pins[9] = 1;
    #10 chk("R9 hi still masked wake_hi", wake_hi, 0);
    tick();
    chk("R9 hi still masked irq_hi", irq_hi, 0);
    pins[9] = 0;
    tick();
    write_masks('1, '1);

    for (int i = 0; i < N; i++) begin
      for (int dir = 0; dir < 2; dir++) begin
        automatic bit hi = (i >= LO_W);
        pins[i] = ~pins[i];
        #10;
        // R5 / R8
        chk(hi ? "R8 wake_hi on change" : "R8 wake_lo on change", hi ? wake_hi : wake_lo, 1);
        chk(hi ? "R5 irq_hi not early" : "R5 irq_lo not early", hi ? irq_hi : irq_lo, 0);
        @(posedge clk); #5;
        // R2 / R3
        chk(hi ? "R3 irq_hi set" : "R2 irq_lo set", hi ? irq_hi : irq_lo, 1);
        chk(hi ? "R3 irq_lo quiet" : "R2 irq_hi quiet", hi ? irq_lo : irq_hi, 0);
        chk("R8 wake drops after sample", wake_lo | wake_hi, 0);
        tick(); tick();
        chk(hi ? "R6 irq_hi held" : "R6 irq_lo held", hi ? irq_hi : irq_lo, 1);
        clear_both();
        chk("R6 cleared", irq_lo | irq_hi, 0);
      end
    end

    for (int i = 0; i < N; i++) begin
      automatic logic [N-1:0] m = ~(12'(1) << i);
      write_masks(m[LO_W-1:0], m[N-1:LO_W]);
      pins[i] = ~pins[i];
      #10;
      // R4
      chk("R4 masked no wake", wake_lo | wake_hi, 0);
      @(posedge clk); #5;
      chk("R4 masked no flag", irq_lo | irq_hi, 0);
      write_masks('1, '1);
      chk("R4 no stale wake", wake_lo | wake_hi, 0);
      tick();
      chk("R4 no stale flag", irq_lo | irq_hi, 0);
    end

    // R7: change and clear at the same edge
    pins[3] = ~pins[3];
    clr_lo = 1;
    tick();
    clr_lo = 0;
    chk("R7 set wins lo", irq_lo, 1);
    pins[10] = ~pins[10];
    clr_hi = 1; clr_lo = 1;
    tick();
    clr_hi = 0; clr_lo = 0;
    chk("R7 set wins hi", irq_hi, 1);
    chk("R6 lo cleared beside hi", irq_lo, 0);
    clear_both();

    // R8: clock stopped low
    #7 clk_en = 0;
    #3 pins[9] = ~pins[9];
    #1;
    chk("R8 wake_hi with clock stopped", wake_hi, 1);
    chk("R8 no flag without clock", irq_hi, 0);
    #200;
    chk("R8 wake_hi held stopped", wake_hi, 1);
    chk("R8 irq_hi held stopped", irq_hi, 0);
    clk_en = 1;
    @(posedge clk); #5;
    chk("R8 flag on restart", irq_hi, 1);
    chk("R8 wake cleared on restart", wake_hi, 0);
    clear_both();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule